// File: doc/BRIEF.md
# Warp Issue Gate with Register Scoreboard

This block sits between instruction fetch and the execution pipeline of one warp. Fetched instructions enter a small in-order buffer. Each instruction carries an opaque opcode payload, one destination register id and two source register ids, and each of these fields has its own valid bit. The block keeps a scoreboard of destination registers that are still being written. The instruction at the head of the buffer is offered for issue only when none of its valid register fields matches a live scoreboard entry, and only when the scoreboard can record its destination.

When an instruction issues, its destination id goes into the lowest free scoreboard slot. The execution side reports each finished write with a completion pulse that carries the register id, and the matching entry is released. A completion is applied before the hazard check in the same cycle, so an instruction that waits on that register can issue in the cycle its producer retires. Fetch uses a valid/ready handshake, and ready drops while the buffer is full.

Top module: `warp_issue_gate`

## Requirements
- R1: Reset (asynchronous, active low) empties the buffer and the scoreboard. Afterwards `fetch_ready` is 1, `issue_valid` is 0, and no register is treated as pending.
- R2: `fetch_ready` is 0 exactly while the buffer holds DEPTH (default 4) instructions. A fetch offered while `fetch_ready` is 0 is discarded and never issues.
- R3: Instructions issue in fetch order. While `issue_valid` is 1, `issue_op`, `issue_dst_vld` and `issue_dst` show the oldest buffered instruction. An instruction cannot issue in the cycle it is fetched.
- R4: `issue_valid` is 0 while a valid source field of the head instruction matches a live scoreboard entry.
- R5: `issue_valid` is 0 while the valid destination field of the head instruction matches a live scoreboard entry.
- R6: A field whose valid bit is 0 takes no part in the hazard check and is not recorded in the scoreboard.
- R7: Issue (`issue_valid` and `issue_ready` both 1) records a valid destination in a free scoreboard entry. With all SB_N (default 4) entries live, a head that has a valid destination is held, and a head without one may still issue.
- R8: `cmpl_valid` releases the entry holding `cmpl_dst`. In the same cycle, the hazard and free-entry checks already see that entry as released.
- R9: A held head instruction also holds every younger instruction, even ones without a hazard.
- R10: While `issue_valid` is 1 and `issue_ready` is 0, the head stays offered unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_ready | output | 1 | Buffer has room |
| fetch_op | input | OP_W | Opaque instruction payload |
| fetch_dst_vld | input | 1 | Destination field in use |
| fetch_dst | input | 5 | Destination register id |
| fetch_src0_vld | input | 1 | First source in use |
| fetch_src0 | input | 5 | First source register id |
| fetch_src1_vld | input | 1 | Second source in use |
| fetch_src1 | input | 5 | Second source register id |
| issue_valid | output | 1 | Head instruction may issue |
| issue_ready | input | 1 | Execution accepts the instruction |
| issue_op | output | OP_W | Payload of the head instruction |
| issue_dst_vld | output | 1 | Head destination in use |
| issue_dst | output | 5 | Head destination register id |
| cmpl_valid | input | 1 | A register write has completed |
| cmpl_dst | input | 5 | Register id of the completed write |

## Verification
Assertions check on every cycle that the buffer is never pushed while full or popped while empty. They also check that an insertion always finds a free scoreboard slot, that no register id is live in two slots at once, and that an offered but unaccepted head stays offered unchanged. Only the bench's scenarios show the issue order, the hazard cases for each operand field, the same-cycle release, the blocking of younger instructions behind a stalled head, the handling of a full scoreboard, the discarding of a refused fetch, and the clearing done by reset.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
   localparam int unsigned REG_W = 5;

   typedef logic [REG_W-1:0] reg_id_t;

   typedef struct packed {
      logic    vld;
      reg_id_t id;
   } opnd_t;

   typedef struct packed {
      opnd_t dst;
      opnd_t src0;
      opnd_t src1;
   } regs_t;

   localparam int unsigned REGS_W = $bits(regs_t);
endpackage

// File: rtl/wsb_ibuf.sv
module wsb_ibuf #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = ((1 << PTR_W) == DEPTH);

   if (DEPTH < 2) begin : g_chk_depth
      $error("wsb_ibuf: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;

   if (POW2) begin : g_wrap_free
      always_comb begin
         wr_nxt = wr_ptr + 1'b1;
         rd_nxt = rd_ptr + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_comb begin
         wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rd_ptr];
   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/wsb_scoreboard.sv
module wsb_scoreboard
   import wsb_pkg::*;
#(
   parameter int unsigned SB_N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_en,
   input  reg_id_t              clr_id,
   input  logic                 ins_en,
   input  reg_id_t              ins_id,
   output logic [SB_N-1:0]      live,
   output reg_id_t [SB_N-1:0]   ids,
   output logic                 has_free
);
   localparam int unsigned IDX_W = (SB_N > 1) ? $clog2(SB_N) : 1;

   if (SB_N < 1) begin : g_chk_n
      $error("wsb_scoreboard: SB_N must be at least 1");
   end

   logic [SB_N-1:0]    vld_q;
   reg_id_t [SB_N-1:0] id_q;
   logic [IDX_W-1:0]   free_idx;

   // release first, so the same-cycle view already excludes the completed id
   for (genvar i = 0; i < SB_N; i++) begin : g_clr
      assign live[i] = vld_q[i] && !(clr_en && (id_q[i] == clr_id));
   end

   assign ids      = id_q;
   assign has_free = ~&live;

   always_comb begin
      free_idx = '0;
      for (int i = SB_N - 1; i >= 0; i--) begin
         if (!live[i]) free_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         id_q  <= '0;
      end else begin
         vld_q <= live;
         if (ins_en) begin
            vld_q[free_idx] <= 1'b1;
            id_q[free_idx]  <= ins_id;
         end
      end
   end

   function automatic logic dup_live(input logic [SB_N-1:0] v,
                                     input reg_id_t [SB_N-1:0] r);
      logic d;
      d = 1'b0;
      for (int a = 0; a < SB_N; a++)
         for (int b = a + 1; b < SB_N; b++)
            if (v[a] && v[b] && (r[a] == r[b])) d = 1'b1;
      return d;
   endfunction

   a_r7_insert_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> has_free);
   a_r5_unique_ids: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_live(vld_q, id_q));
endmodule

// File: rtl/wsb_hazard.sv
module wsb_hazard
   import wsb_pkg::*;
#(
   parameter int unsigned SB_N = 4
) (
   input  regs_t               regs,
   input  logic [SB_N-1:0]     live,
   input  reg_id_t [SB_N-1:0]  ids,
   output logic                hazard
);
   logic [SB_N-1:0] hit;

   for (genvar i = 0; i < SB_N; i++) begin : g_cmp
      logic m_dst, m_s0, m_s1;
      assign m_dst  = regs.dst.vld  && (regs.dst.id  == ids[i]);
      assign m_s0   = regs.src0.vld && (regs.src0.id == ids[i]);
      assign m_s1   = regs.src1.vld && (regs.src1.id == ids[i]);
      assign hit[i] = live[i] && (m_dst || m_s0 || m_s1);
   end

   assign hazard = |hit;
endmodule

// File: rtl/warp_issue_gate.sv
module warp_issue_gate
   import wsb_pkg::*;
#(
   parameter int unsigned OP_W  = 8,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned SB_N  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_valid,
   output logic             fetch_ready,
   input  logic [OP_W-1:0]  fetch_op,
   input  logic             fetch_dst_vld,
   input  logic [REG_W-1:0] fetch_dst,
   input  logic             fetch_src0_vld,
   input  logic [REG_W-1:0] fetch_src0,
   input  logic             fetch_src1_vld,
   input  logic [REG_W-1:0] fetch_src1,
   output logic             issue_valid,
   input  logic             issue_ready,
   output logic [OP_W-1:0]  issue_op,
   output logic             issue_dst_vld,
   output logic [REG_W-1:0] issue_dst,
   input  logic             cmpl_valid,
   input  logic [REG_W-1:0] cmpl_dst
);
   localparam int unsigned ENT_W = OP_W + REGS_W;

   if (OP_W < 1) begin : g_chk_op
      $error("warp_issue_gate: OP_W must be at least 1");
   end

   regs_t             in_regs, hd_regs;
   logic [OP_W-1:0]   hd_op;
   logic [ENT_W-1:0]  hd_ent;
   logic              buf_empty, buf_full, push, fire;
   logic [SB_N-1:0]   sb_live;
   reg_id_t [SB_N-1:0] sb_ids;
   logic              sb_free, hazard, can_alloc;

   assign in_regs.dst  = '{vld: fetch_dst_vld,  id: fetch_dst};
   assign in_regs.src0 = '{vld: fetch_src0_vld, id: fetch_src0};
   assign in_regs.src1 = '{vld: fetch_src1_vld, id: fetch_src1};

   assign fetch_ready = !buf_full;
   assign push        = fetch_valid && fetch_ready;

   wsb_ibuf #(.W(ENT_W), .DEPTH(DEPTH)) u_ibuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({fetch_op, in_regs}),
      .pop   (fire),
      .dout  (hd_ent),
      .empty (buf_empty),
      .full  (buf_full)
   );

   assign {hd_op, hd_regs} = hd_ent;

   wsb_scoreboard #(.SB_N(SB_N)) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (cmpl_valid),
      .clr_id   (cmpl_dst),
      .ins_en   (fire && hd_regs.dst.vld),
      .ins_id   (hd_regs.dst.id),
      .live     (sb_live),
      .ids      (sb_ids),
      .has_free (sb_free)
   );

   wsb_hazard #(.SB_N(SB_N)) u_hz (
      .regs   (hd_regs),
      .live   (sb_live),
      .ids    (sb_ids),
      .hazard (hazard)
   );

   assign can_alloc     = !hd_regs.dst.vld || sb_free;
   assign issue_valid   = !buf_empty && !hazard && can_alloc;
   assign fire          = issue_valid && issue_ready;
   assign issue_op      = hd_op;
   assign issue_dst_vld = hd_regs.dst.vld;
   assign issue_dst     = hd_regs.dst.id;

   a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_op)
                                         && $stable(issue_dst)));
endmodule

// File: tb/sim_warp_issue_gate.sv
module sim_warp_issue_gate;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       fetch_valid, fetch_ready, fetch_dst_vld, fetch_src0_vld, fetch_src1_vld;
   logic [7:0] fetch_op, issue_op;
   logic [4:0] fetch_dst, fetch_src0, fetch_src1, issue_dst, cmpl_dst;
   logic       issue_valid, issue_ready, issue_dst_vld, cmpl_valid;

   warp_issue_gate u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_op(fetch_op),
      .fetch_dst_vld(fetch_dst_vld), .fetch_dst(fetch_dst),
      .fetch_src0_vld(fetch_src0_vld), .fetch_src0(fetch_src0),
      .fetch_src1_vld(fetch_src1_vld), .fetch_src1(fetch_src1),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
      .issue_dst_vld(issue_dst_vld), .issue_dst(issue_dst),
      .cmpl_valid(cmpl_valid), .cmpl_dst(cmpl_dst)
   );

   typedef struct packed {
      logic fv; logic [7:0] op;
      logic dv; logic [4:0] d; logic s0v; logic [4:0] s0; logic s1v; logic [4:0] s1;
      logic ir; logic cv; logic [4:0] cid;
      logic efr; logic eiv; logic [7:0] eop; logic [3:0] req;
   } vec_t;

   function automatic vec_t v(int fv, int op, int dv, int d, int s0v, int s0, int s1v,
                              int s1, int ir, int cv, int cid, int efr, int eiv,
                              int eop, int req);
      vec_t r;
      r.fv = fv[0]; r.op = op[7:0]; r.dv = dv[0]; r.d = d[4:0];
      r.s0v = s0v[0]; r.s0 = s0[4:0]; r.s1v = s1v[0]; r.s1 = s1[4:0];
      r.ir = ir[0]; r.cv = cv[0]; r.cid = cid[4:0];
      r.efr = efr[0]; r.eiv = eiv[0]; r.eop = eop[7:0]; r.req = req[3:0];
      return r;
   endfunction

   localparam int NV = 30;
   // fv op dv d s0v s0 s1v s1 ir cv cid | efr eiv eop | req
   localparam vec_t VEC [NV] = '{
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,0,8'h00, 1),  // R1 idle after reset
      v(1,8'h11,1,1,0,0,0,0, 1,0,0, 1,0,8'h00, 3),  // R3 no same-cycle issue
      v(1,8'h12,1,2,1,1,0,0, 1,0,0, 1,1,8'h11, 3),  // R3 head offered
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,0,8'h00, 4),  // R4 src0 r1 pending
      v(0,8'h00,0,0,0,0,0,0, 1,1,1, 1,1,8'h12, 8),  // R8 same-cycle release
      v(1,8'h13,1,2,0,0,0,0, 1,0,0, 1,0,8'h00, 3),
      v(1,8'h14,1,7,0,0,0,0, 1,0,0, 1,0,8'h00, 5),  // R5 dst r2 pending
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,0,8'h00, 9),  // R9 younger held
      v(0,8'h00,0,0,0,0,0,0, 0,1,2, 1,1,8'h13,10),  // R10 offered, refused
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,1,8'h13,10),  // R10 still offered
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,1,8'h14, 9),  // R9 order kept
      v(1,8'h15,0,7,0,2,1,9, 1,0,0, 1,0,8'h00, 6),
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,1,8'h15, 6),  // R6 unused r7/r2 ignored
      v(1,8'h16,1,3,0,0,0,0, 1,0,0, 1,0,8'h00, 3),
      v(1,8'h17,1,4,0,0,0,0, 1,0,0, 1,1,8'h16, 3),
      v(1,8'h18,1,5,0,0,0,0, 1,0,0, 1,1,8'h17, 3),  // scoreboard now full
      v(1,8'h19,0,0,1,20,0,0,1,0,0, 1,0,8'h00, 7),  // R7 no free slot
      v(0,8'h00,0,0,0,0,0,0, 1,1,7, 1,1,8'h18, 8),  // R8 release frees slot
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,1,8'h19, 7),  // R7 no dst, full board
      v(1,8'h20,1,2,0,0,0,0, 1,0,0, 1,0,8'h00, 2),
      v(1,8'h21,1,2,0,0,0,0, 1,0,0, 1,0,8'h00, 2),
      v(1,8'h22,1,2,0,0,0,0, 1,0,0, 1,0,8'h00, 2),
      v(1,8'h23,1,2,0,0,0,0, 1,0,0, 1,0,8'h00, 2),
      v(1,8'h24,1,2,0,0,0,0, 1,0,0, 0,0,8'h00, 2),  // R2 full, refused
      v(0,8'h00,0,0,0,0,0,0, 1,1,2, 0,1,8'h20, 8),
      v(0,8'h00,0,0,0,0,0,0, 1,0,0, 1,0,8'h00, 5),
      v(0,8'h00,0,0,0,0,0,0, 1,1,2, 1,1,8'h21, 3),
      v(0,8'h00,0,0,0,0,0,0, 1,1,2, 1,1,8'h22, 3),
      v(0,8'h00,0,0,0,0,0,0, 1,1,2, 1,1,8'h23, 3),
      v(0,8'h00,0,0,0,0,0,0, 1,1,2, 1,0,8'h00, 2)   // R2 refused op never seen
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic drive(input vec_t x);
      fetch_valid = x.fv; fetch_op = x.op;
      fetch_dst_vld = x.dv; fetch_dst = x.d;
      fetch_src0_vld = x.s0v; fetch_src0 = x.s0;
      fetch_src1_vld = x.s1v; fetch_src1 = x.s1;
      issue_ready = x.ir; cmpl_valid = x.cv; cmpl_dst = x.cid;
   endtask

   task automatic step(input vec_t x, input string req);
      @(negedge clk);
      drive(x);
      #1;
      chk(req, "fetch_ready", int'(fetch_ready), int'(x.efr));
      chk(req, "issue_valid", int'(issue_valid), int'(x.eiv));
      if (x.eiv) chk(req, "issue_op", int'(issue_op), int'(x.eop));
   endtask

   initial begin
      drive(v(0,0,0,0,0,0,0,0,0,0,0,0,0,0,0));
      #1;
      chk("R1", "fetch_ready in reset", int'(fetch_ready), 1);
      chk("R1", "issue_valid in reset", int'(issue_valid), 0);
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) step(VEC[i], $sformatf("R%0d", VEC[i].req));

      // R5 pending r5 holds a new instruction, then R1 reset clears all
      step(v(1,8'h30,1,5,0,0,0,0, 1,0,0, 1,0,0, 0), "R3");
      step(v(0,0,0,0,0,0,0,0, 1,0,0, 1,0,0, 0), "R5");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "fetch_ready after reset", int'(fetch_ready), 1);
      chk("R1", "issue_valid after reset", int'(issue_valid), 0);
      @(negedge clk) rst_n = 1'b1;
      step(v(1,8'h31,1,5,0,0,0,0, 1,0,0, 1,0,0, 0), "R1");
      step(v(1,8'h32,0,5,0,5,0,5, 1,0,0, 1,1,8'h31, 0), "R1");
      chk("R3", "issue_dst_vld", int'(issue_dst_vld), 1);
      chk("R3", "issue_dst", int'(issue_dst), 5);
      step(v(1,8'h33,0,0,0,0,1,5, 1,0,0, 1,1,8'h32, 0), "R6");
      step(v(0,0,0,0,0,0,0,0, 1,0,0, 1,0,0, 0), "R4");
      step(v(0,0,0,0,0,0,0,0, 1,1,5, 1,1,8'h33, 0), "R8");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule